// File: doc/BRIEF.md
# Fieldbus-Synchronized Real-Time Strobe Generator

This block produces a periodic one-clock strobe that paces the real-time tasks of a drive, and slowly pulls that strobe into a fixed phase relation with a once-per-cycle sync event sent by a fieldbus master. A saturating counter measures the time since the most recent sync event. At the first strobe of every fieldbus cycle, the counter value is captured as the measured delay. That delay is compared with a programmed target, and only the strobe period that starts at that instant is stretched or shrunk by a clamped, proportional amount. All other periods stay at the nominal length.

A lock detector counts consecutive samples that fall strictly inside a tolerance window around the target. It asserts its output once the count reaches a programmed threshold and drops it at the first miss. The sync event can come from a distributed-clock event or from a process-data arrival event, chosen by a control bit. A second control bit turns the correction on. When sync events stop, the generator falls back to the nominal period and clears lock.

With the default 100 MHz clock, the nominal period is 6250 clocks (62.5 µs) and the largest single correction is 30 clocks (300 ns). That step is 4800 ppm of one period.

Top module: `fieldbus_strobe_sync`

## Requirements
- R1: While reset is active, and in the cycle after it is released, `strobe` is 0, `locked` is 0 and `act_delay` is 0. The first strobe after release comes exactly NOM_PERIOD clocks after the reset period.
- R2: `strobe` is a one-clock pulse. Every period that does not start at a sample strobe lasts exactly NOM_PERIOD clocks.
- R3: A fieldbus cycle spans `spc` strobes, and an `spc` of 0 acts as 1. The sample strobe is the first strobe of each cycle, and the first strobe after reset is a sample strobe.
- R4: The delay counter clears on each clock where the selected sync input is high, increments on every other clock and saturates at its maximum. On a sample strobe, `act_delay` takes the counter value held in that cycle, before any clear in the same cycle, and shows it from the next cycle on.
- R5: When correction is active, the period that starts at a sample strobe lasts NOM_PERIOD + clamp(floor((exp_delay − sample)/8), −MAX_STEP, +MAX_STEP) clocks. Only that one period is affected.
- R6: A qualified sample lies in the window when exp_delay − win < sample < exp_delay + win, with both inequalities strict. An in-window sample increments a saturating run count, and `locked` becomes 1 once the count is at least `lock_thresh`. An out-of-window sample zeroes the count and clears `locked`.
- R7: `locked` changes only in the cycle after a sample strobe.
- R8: A sample is stale when at least two sample strobes have passed since the last selected sync event, or when no event has arrived since reset. A stale sample gives a nominal period, zeroes the run count and clears `locked`.
- R9: `ctrl[0]` = 1 enables correction. When it is 0, each sample gives a nominal period and clears `locked`, while `act_delay` is still captured.
- R10: `ctrl[1]` = 1 selects `dc_evt` as the sync source and 0 selects `pd_evt`. Pulses on the unselected input have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 2 | Bit 0: correction enable; bit 1: source select (1 = distributed clock) |
| dc_evt | input | 1 | Distributed-clock sync pulse |
| pd_evt | input | 1 | Process-data arrival pulse |
| spc | input | SPC_W | Strobes per fieldbus cycle |
| exp_delay | input | CNT_W | Target sync-to-sample delay in clocks |
| win | input | CNT_W | Half-width of the lock window |
| lock_thresh | input | LOCK_W | Consecutive in-window samples needed for lock |
| strobe | output | 1 | Real-time strobe pulse |
| act_delay | output | CNT_W | Delay captured at the last sample strobe |
| locked | output | 1 | Synchronization lock indication |

## Verification
The bench predicts the length of every strobe interval. A design that applied the correction to the wrong strobe, or kept it for more than one period, would produce an interval that differs from the prediction. Large target errors drive the step into its clamp, and a clamp with the wrong sign or bound would show up as a period off by the excess. Samples that land exactly on a window edge expose a non-strict compare as a spurious lock. Sync events that coincide with a sample strobe show whether the capture reads the counter before or after the clear. Muting the master, clearing the enable bit and pulsing the unselected source each check that the period returns to nominal and lock drops, rather than being steered by stale or foreign events.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // control word bit positions
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SRC_BIT = 1;

  typedef enum logic {
    SRC_PDATA = 1'b0,
    SRC_DCLK  = 1'b1
  } sync_src_e;

  // missed-sample counter saturates here; reaching it marks the loop stale
  localparam logic [1:0] MISS_LIMIT = 2'd2;
endpackage

// File: rtl/ssp_strobe_timer.sv
module ssp_strobe_timer #(
  parameter int NOM_PERIOD = 6250,
  parameter int MAX_STEP   = 30,
  parameter int SPC_W      = 8,
  parameter int PER_W      = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SPC_W-1:0] spc,
  input  logic [PER_W-1:0] corr_period,
  output logic             strobe,
  output logic             sample
);
  localparam logic [PER_W-1:0] NOM_P = PER_W'(NOM_PERIOD);
  localparam logic [PER_W-1:0] MIN_P = PER_W'(NOM_PERIOD - MAX_STEP);
  localparam logic [PER_W-1:0] MAX_P = PER_W'(NOM_PERIOD + MAX_STEP);

  logic [PER_W-1:0] pcnt_q, pcnt_d;
  logic [PER_W-1:0] period_q, period_d;
  logic [SPC_W-1:0] sidx_q, sidx_d;
  logic [SPC_W-1:0] spc_last;

  // a cycle length of zero behaves as one strobe per cycle
  assign spc_last = (spc == '0) ? '0 : spc - 1'b1;
  assign strobe   = (pcnt_q == period_q - 1'b1);
  assign sample   = strobe && (sidx_q == '0);

  always_comb begin
    pcnt_d   = pcnt_q + 1'b1;
    period_d = period_q;
    sidx_d   = sidx_q;
    if (strobe) begin
      pcnt_d   = '0;
      period_d = sample ? corr_period : NOM_P;
      sidx_d   = (sidx_q >= spc_last) ? '0 : sidx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q   <= '0;
      period_q <= NOM_P;
      sidx_q   <= '0;
    end else begin
      pcnt_q   <= pcnt_d;
      period_q <= period_d;
      sidx_q   <= sidx_d;
    end
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (period_q >= MIN_P) && (period_q <= MAX_P)); // R5

  AST_PLAIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !sample) |=> (period_q == NOM_P)); // R2

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe); // R2
endmodule

// File: rtl/ssp_delay_meter.sv
module ssp_delay_meter
  import ssp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dc_evt,
  input  logic             pd_evt,
  input  sync_src_e        src,
  input  logic             sample,
  output logic [CNT_W-1:0] dly,
  output logic [CNT_W-1:0] act_q,
  output logic             stale
);
  logic             evt;
  logic [CNT_W-1:0] dcnt_d, act_d;
  logic [1:0]       miss_q, miss_d;

  assign evt   = (src == SRC_DCLK) ? dc_evt : pd_evt;
  assign stale = (miss_q >= MISS_LIMIT);

  always_comb begin
    dcnt_d = (dly == '1) ? dly : dly + 1'b1;
    if (evt) dcnt_d = '0;

    miss_d = miss_q;
    if (evt)                miss_d = '0;
    else if (sample && !stale) miss_d = miss_q + 1'b1;

    act_d = act_q;
    if (sample) act_d = dly;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly    <= '0;
      act_q  <= '0;
      miss_q <= MISS_LIMIT;
    end else begin
      dly    <= dcnt_d;
      act_q  <= act_d;
      miss_q <= miss_d;
    end
  end

  AST_CLEAR_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (dly == '0)); // R4

  AST_STALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stale && !evt) |=> stale); // R8

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(act_q)); // R4
endmodule

// File: rtl/ssp_loop_filter.sv
module ssp_loop_filter #(
  parameter int NOM_PERIOD = 6250,
  parameter int MAX_STEP   = 30,
  parameter int SHIFT      = 3,
  parameter int CNT_W      = 16,
  parameter int PER_W      = 13
) (
  input  logic [CNT_W-1:0] exp_delay,
  input  logic [CNT_W-1:0] dly,
  input  logic             qualify,
  output logic [PER_W-1:0] corr_period
);
  localparam int DW = CNT_W + 2;
  localparam logic [PER_W-1:0]    NOM_P = PER_W'(NOM_PERIOD);
  localparam logic signed [DW-1:0] MAXS = DW'(MAX_STEP);

  logic signed [DW-1:0] diff, step, step_c;

  always_comb begin
    diff = $signed({2'b00, exp_delay}) - $signed({2'b00, dly});
    // arithmetic shift rounds toward minus infinity
    step = diff >>> SHIFT;
    if (step > MAXS)       step_c = MAXS;
    else if (step < -MAXS) step_c = -MAXS;
    else                   step_c = step;
    corr_period = qualify ? (NOM_P + PER_W'(step_c)) : NOM_P;
  end
endmodule

// File: rtl/ssp_lock_det.sv
module ssp_lock_det #(
  parameter int CNT_W  = 16,
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              qualify,
  input  logic [CNT_W-1:0]  dly,
  input  logic [CNT_W-1:0]  exp_delay,
  input  logic [CNT_W-1:0]  win,
  input  logic [LOCK_W-1:0] lock_thresh,
  output logic              locked
);
  localparam int DW = CNT_W + 2;

  logic signed [DW-1:0] a_s, lo_s, hi_s;
  logic                 inwin;
  logic [LOCK_W-1:0]    run_q, run_d, run_inc;
  logic                 locked_d;

  assign a_s   = $signed({2'b00, dly});
  assign lo_s  = $signed({2'b00, exp_delay}) - $signed({2'b00, win});
  assign hi_s  = $signed({2'b00, exp_delay}) + $signed({2'b00, win});
  assign inwin = (a_s > lo_s) && (a_s < hi_s);

  assign run_inc = (run_q == '1) ? run_q : run_q + 1'b1;

  always_comb begin
    run_d    = run_q;
    locked_d = locked;
    if (sample) begin
      if (qualify && inwin) begin
        run_d    = run_inc;
        locked_d = (run_inc >= lock_thresh);
      end else begin
        run_d    = '0;
        locked_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      locked <= 1'b0;
    end else begin
      run_q  <= run_d;
      locked <= locked_d;
    end
  end

  AST_LOCK_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(locked)); // R7

  AST_OUTWIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !inwin) |=> !locked); // R6

  AST_UNQUAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !qualify) |=> (!locked && run_q == '0)); // R8
endmodule

// File: rtl/fieldbus_strobe_sync.sv
module fieldbus_strobe_sync
  import ssp_pkg::*;
#(
  parameter int NOM_PERIOD = 6250,
  parameter int MAX_STEP   = 30,
  parameter int SHIFT      = 3,
  parameter int CNT_W      = 16,
  parameter int SPC_W      = 8,
  parameter int LOCK_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctrl,
  input  logic              dc_evt,
  input  logic              pd_evt,
  input  logic [SPC_W-1:0]  spc,
  input  logic [CNT_W-1:0]  exp_delay,
  input  logic [CNT_W-1:0]  win,
  input  logic [LOCK_W-1:0] lock_thresh,
  output logic              strobe,
  output logic [CNT_W-1:0]  act_delay,
  output logic              locked
);
  localparam int PER_W = $clog2(NOM_PERIOD + MAX_STEP + 1);

  logic             sample;
  logic             stale;
  logic             qualify;
  logic [CNT_W-1:0] dly;
  logic [PER_W-1:0] corr_period;
  sync_src_e        src;

  assign src     = sync_src_e'(ctrl[CTRL_SRC_BIT]);
  assign qualify = ctrl[CTRL_EN_BIT] && !stale;

  ssp_strobe_timer #(
    .NOM_PERIOD (NOM_PERIOD),
    .MAX_STEP   (MAX_STEP),
    .SPC_W      (SPC_W),
    .PER_W      (PER_W)
  ) i_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .spc         (spc),
    .corr_period (corr_period),
    .strobe      (strobe),
    .sample      (sample)
  );

  ssp_delay_meter #(
    .CNT_W (CNT_W)
  ) i_meter (
    .clk    (clk),
    .rst_n  (rst_n),
    .dc_evt (dc_evt),
    .pd_evt (pd_evt),
    .src    (src),
    .sample (sample),
    .dly    (dly),
    .act_q  (act_delay),
    .stale  (stale)
  );

  ssp_loop_filter #(
    .NOM_PERIOD (NOM_PERIOD),
    .MAX_STEP   (MAX_STEP),
    .SHIFT      (SHIFT),
    .CNT_W      (CNT_W),
    .PER_W      (PER_W)
  ) i_filter (
    .exp_delay   (exp_delay),
    .dly         (dly),
    .qualify     (qualify),
    .corr_period (corr_period)
  );

  ssp_lock_det #(
    .CNT_W  (CNT_W),
    .LOCK_W (LOCK_W)
  ) i_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample      (sample),
    .qualify     (qualify),
    .dly         (dly),
    .exp_delay   (exp_delay),
    .win         (win),
    .lock_thresh (lock_thresh),
    .locked      (locked)
  );

  AST_DISABLED_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !ctrl[CTRL_EN_BIT]) |=> !locked); // R9
endmodule

// File: tb/test_fieldbus_strobe_sync.sv
module test_fieldbus_strobe_sync;
  localparam int CLK_PERIOD = 10;
  localparam int NOM    = 200;
  localparam int MAXS   = 10;
  localparam int CNT_W  = 12;
  localparam int SPC_W  = 4;
  localparam int LOCK_W = 4;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;
  localparam int RUN_MAX  = (1 << LOCK_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        ctrl;
  logic              dc_evt, pd_evt;
  logic [SPC_W-1:0]  spc;
  logic [CNT_W-1:0]  exp_delay, win;
  logic [LOCK_W-1:0] lock_thresh;
  logic              strobe;
  logic [CNT_W-1:0]  act_delay;
  logic              locked;

  always #(CLK_PERIOD/2) clk = ~clk;

  fieldbus_strobe_sync #(
    .NOM_PERIOD (NOM), .MAX_STEP (MAXS), .SHIFT (3),
    .CNT_W (CNT_W), .SPC_W (SPC_W), .LOCK_W (LOCK_W)
  ) i_fieldbus_strobe_sync (
    .clk (clk), .rst_n (rst_n), .ctrl (ctrl), .dc_evt (dc_evt), .pd_evt (pd_evt),
    .spc (spc), .exp_delay (exp_delay), .win (win), .lock_thresh (lock_thresh),
    .strobe (strobe), .act_delay (act_delay), .locked (locked)
  );

  int n_total = 0, n_fail = 0;
  bit done = 0;

  // configuration staged between ticks, applied right after a falling edge
  int n_ctrl = 1, n_spc = 2, n_exp = 100, n_win = 10, n_thr = 3;
  // master model
  int mper = 400, mcnt = 0;
  bit mute = 0, noise = 0;
  // reference model state
  int m_dly = 1, m_miss = 2, m_sidx = 0, m_run = 0, m_gap = 1;
  int exp_per = NOM;
  string per_tag = "R1";
  bit m_lock = 0, pend = 0;
  int e_act = 0;
  string act_tag = "R4";

  task automatic chk(input bit ok, input string tag, input int act, input int expv,
                     input string what);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle time %0t)", tag, what, act, expv, $time);
    end
  endtask

  function automatic int floor_div8(input int d);
    if (d >= 0) return d / 8;
    return -((-d + 7) / 8);
  endfunction

  function automatic int clampi(input int v, input int lim);
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  task automatic tick();
    bit sel_ev, smp, fire;
    int spc_e, diff, corr;
    @(negedge clk);
    ctrl = n_ctrl[1:0]; spc = n_spc[SPC_W-1:0]; exp_delay = n_exp[CNT_W-1:0];
    win = n_win[CNT_W-1:0]; lock_thresh = n_thr[LOCK_W-1:0];
    fire = 0;
    if (mcnt >= mper - 1) begin mcnt = 0; fire = !mute; end
    else mcnt++;
    dc_evt = ctrl[1] ? fire : (noise && ($urandom % 40 == 0));
    pd_evt = ctrl[1] ? (noise && ($urandom % 40 == 0)) : fire;
    sel_ev = ctrl[1] ? dc_evt : pd_evt;

    if (pend) begin
      chk(act_delay == e_act[CNT_W-1:0], act_tag, int'(act_delay), e_act, "captured delay");
      pend = 0;
    end
    // lock only follows the model, whose value moves at sample instants (R7)
    chk(locked == m_lock, "R6 R7", int'(locked), int'(m_lock), "lock state");

    m_gap++;
    smp = 0;
    if (strobe) begin
      chk(m_gap == exp_per, per_tag, m_gap, exp_per, "strobe interval");
      m_gap = 0;
      smp = (m_sidx == 0);
      spc_e = (n_spc == 0) ? 1 : n_spc;
      m_sidx = (m_sidx >= spc_e - 1) ? 0 : m_sidx + 1;
      if (smp) begin
        e_act = m_dly;
        act_tag = ctrl[1] ? "R4" : "R4 R10";
        pend = 1;
        if (ctrl[0] && m_miss < 2) begin
          diff = n_exp - m_dly;
          corr = clampi(floor_div8(diff), MAXS);
          exp_per = NOM + corr;
          per_tag = "R5";
          if ((m_dly > n_exp - n_win) && (m_dly < n_exp + n_win)) begin
            if (m_run < RUN_MAX) m_run++;
            m_lock = (m_run >= n_thr);
          end else begin
            m_run = 0; m_lock = 0;
          end
        end else begin
          exp_per = NOM;
          per_tag = ctrl[0] ? "R8" : "R9";
          m_run = 0; m_lock = 0;
        end
      end else begin
        exp_per = NOM;
        per_tag = "R2 R3";
      end
    end
    if (sel_ev) m_miss = 0;
    else if (smp && m_miss < 2) m_miss++;
    m_dly = sel_ev ? 0 : ((m_dly < CNT_MAX) ? m_dly + 1 : m_dly);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0042);
    rst_n = 1'b0; ctrl = 2'b01; dc_evt = 0; pd_evt = 0; spc = 2;
    exp_delay = 100; win = 10; lock_thresh = 3;
    repeat (4) @(negedge clk);
    chk(strobe == 1'b0, "R1", int'(strobe), 0, "strobe in reset");
    chk(locked == 1'b0, "R1", int'(locked), 0, "lock in reset");
    chk(act_delay == '0, "R1", int'(act_delay), 0, "delay in reset");
    rst_n = 1'b1;  // released on a falling edge

    // converge from an arbitrary phase with an exact master rate
    n_ctrl = 3; n_spc = 2; n_exp = 100; n_win = 10; n_thr = 3; mper = 400; mcnt = 137;
    run(24000);
    chk(locked == 1'b1, "R6", int'(locked), 1, "lock after convergence");

    // slow master drift, tracked by a standing correction
    n_exp = 150; n_win = 8; n_thr = 2; mper = 406;
    run(12000);

    // process-data source, with noise on the unselected input (R10)
    n_ctrl = 1; noise = 1; mper = 395; n_exp = 120;
    run(12000);
    noise = 0;

    // zero strobes per cycle behaves as one (R3)
    n_spc = 0; mper = 200; n_exp = 60; n_win = 6;
    run(6000);

    // far target forces the clamp (R5)
    n_spc = 2; mper = 400; n_exp = 390; n_ctrl = 3;
    run(4000);

    // events stop: stale loop (R8)
    mute = 1;
    run(2000);
    chk(locked == 1'b0, "R8", int'(locked), 0, "lock after sync loss");
    mute = 0;

    // correction disabled (R9)
    n_ctrl = 2; n_exp = 100;
    run(4000);
    chk(locked == 1'b0, "R9", int'(locked), 0, "lock while disabled");

    // constrained random configurations
    for (int k = 0; k < 5; k++) begin
      n_spc  = 1 + ($urandom % 3);
      n_ctrl = (($urandom % 8) == 0) ? ($urandom % 2) * 2 : 1 + ($urandom % 2) * 2;
      n_exp  = $urandom % (NOM * n_spc);
      n_win  = 1 + ($urandom % 20);
      n_thr  = $urandom % 5;
      mper   = NOM * n_spc + int'($urandom % 17) - 8;
      noise  = ($urandom % 2) == 1;
      run(8000);
    end
    noise = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule